// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

This block holds four independent PWM channels behind one small register bus. Each channel counts down a 16-bit counter at a rate set by its own prescaler (input clock divided by 2, 4, 8 or 16). Software writes a count value and a compare value into per-channel shadow buffers. These buffers never touch the running counter directly. They move into the active counter and the active compare register in two cases: while the channel's manual-load bit is held, or at underflow when repeat mode is on. Each channel drives one PWM pin and a one-cycle wrap pulse at every underflow.

All channels share one control word, and each channel owns a 4-bit field in it. Field order, from the field's lowest bit: run, manual load, invert, repeat. Channel 0's field sits at bit 0. Channel n (n ≥ 1) has its field at bit 4·n + 4, so bits 4..7 are never used. Software changes one channel by reading the word, editing that channel's field and writing it back.

Each channel is a state machine with three states. `CH_IDLE` means halted. `CH_RUN` means counting. `CH_DONE` means a single period has finished with repeat off. The transitions are:
- START: `CH_IDLE`→`CH_RUN` when the run bit is set.
- HALT: `CH_RUN`→`CH_IDLE` when the run bit is cleared.
- EXPIRE: `CH_RUN`→`CH_DONE` on an underflow with repeat clear.
- REARM: `CH_DONE`→`CH_IDLE` when the run bit is cleared.

Top module: `pwmt_bank`

## Requirements
- R1: After reset, every register reads 0, every `pwm_out` bit is 0 and every `pwm_wrap` bit is 0.
- R2: Bus address map: 0 is the control word, 1 is the prescale codes (2 bits per channel at bit 2·n), 4+2·n is channel n's count buffer and 5+2·n is its compare buffer. Control fields sit at bit 0 for channel 0 and at bit 4·n+4 for channel n ≥ 1. All unmapped control bits read 0.
- R3: While a channel's manual-load bit (field bit 1) is set, its buffers are copied into the active counter and compare, its level is forced low and it does not count.
- R4: The counter decrements once per tick. A period lasts count+1 ticks. `pwm_wrap` pulses for exactly one clock at each underflow.
- R5: Prescale code 0, 1, 2 or 3 gives one tick every 2, 4, 8 or 16 clocks. Ticks start counting from zero when the channel enters `CH_RUN`.
- R6: Within one period the raw level is low for count−compare ticks, then high for compare+1 ticks. It returns low at the underflow.
- R7: If compare equals count, the level never goes high, because the compare is checked only after a decrement.
- R8: With repeat set (field bit 3), the underflow reloads both buffers. Buffer writes made during a period do not change that period's length.
- R9: With repeat clear, the channel runs a single period and emits one wrap. Its pin then stays at the low level.
- R10: The invert bit (field bit 2) flips `pwm_out` relative to the raw level.
- R11: Clearing the run bit (field bit 0) halts the counter. The pin holds its value, no wrap occurs, and other channels keep running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | NUM_CH | PWM pin per channel |
| pwm_wrap | output | NUM_CH | One-clock underflow pulse per channel |

## Verification
On every cycle the assertions check four things. A running counter only ever steps down by one unless it is reloading. A held manual-load bit leaves the buffer value in the counter. A halted channel keeps its counter still. Each wrap is a single cycle with the raw level low. Only the bench scenarios can show the actual waveform timing: high and low durations for each prescale code, the inverted waveform, the silent pin when compare equals count, a buffer write landing at the next underflow and not the current one, a single-period run, and a halt on one channel leaving the others running.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned GRP_W  = 4;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_RUN  = 2'd1,
        CH_DONE = 2'd2
    } ch_state_e;

    // Field bit 0 is the LSB: run, manual load, invert, repeat
    typedef struct packed {
        logic repeat_en;
        logic invert;
        logic manual;
        logic run;
    } ch_ctrl_t;

    function automatic int unsigned grp_base(input int unsigned ch);
        return (ch == 0) ? 0 : (4 * ch + 4);
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [DATA_W-1:0]              rdata_o,
    output ch_ctrl_t [NUM_CH-1:0]          ctrl_o,
    output logic [NUM_CH-1:0][1:0]         div_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cnt_buf_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]   cmp_buf_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(1);

    logic unused_wdata;
    assign unused_wdata = ^wdata_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o    <= '0;
            div_o     <= '0;
            cnt_buf_o <= '0;
            cmp_buf_o <= '0;
        end else if (wr_i) begin
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr_i == A_CTRL)
                    ctrl_o[n] <= wdata_i[grp_base(n) +: GRP_W];
                if (addr_i == A_DIV)
                    div_o[n] <= wdata_i[2*n +: 2];
                if (addr_i == ADDR_W'(4 + 2*n))
                    cnt_buf_o[n] <= wdata_i[CNT_W-1:0];
                if (addr_i == ADDR_W'(5 + 2*n))
                    cmp_buf_o[n] <= wdata_i[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr_i == A_CTRL)
                rdata_o[grp_base(n) +: GRP_W] = ctrl_o[n];
            if (addr_i == A_DIV)
                rdata_o[2*n +: 2] = div_o[n];
            if (addr_i == ADDR_W'(4 + 2*n))
                rdata_o[CNT_W-1:0] = cnt_buf_o[n];
            if (addr_i == ADDR_W'(5 + 2*n))
                rdata_o[CNT_W-1:0] = cmp_buf_o[n];
        end
    end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ch_ctrl_t         ctrl_i,
    input  logic [1:0]       div_i,
    input  logic [CNT_W-1:0] cnt_buf_i,
    input  logic [CNT_W-1:0] cmp_buf_i,
    output logic             pwm_o,
    output logic             wrap_o,
    output logic             running_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam int unsigned PRE_W = 4;

    ch_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_q, pre_mask;
    logic [CNT_W-1:0] cnt_q, cmp_q, cnt_dec;
    logic             level_q, wrap_q, tick, under;

    assign pre_mask = PRE_W'((5'd2 << div_i) - 5'd1);
    assign tick     = (state_q == CH_RUN) && !ctrl_i.manual && (pre_q == pre_mask);
    assign under    = tick && (cnt_q == '0);
    assign cnt_dec  = cnt_q - CNT_W'(1);

    // prescaler: restarts whenever the channel is not counting
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != CH_RUN || ctrl_i.manual || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (ctrl_i.run) state_d = CH_RUN;
            CH_RUN: begin
                if (!ctrl_i.run)                    state_d = CH_IDLE;
                else if (under && !ctrl_i.repeat_en) state_d = CH_DONE;
            end
            CH_DONE: if (!ctrl_i.run) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // counter, active compare, level and wrap pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_q   <= '0;
            level_q <= 1'b0;
            wrap_q  <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (ctrl_i.manual) begin
                cnt_q   <= cnt_buf_i;
                cmp_q   <= cmp_buf_i;
                level_q <= 1'b0;
            end else if (tick) begin
                if (under) begin
                    wrap_q  <= 1'b1;
                    level_q <= 1'b0;
                    if (ctrl_i.repeat_en) begin
                        cnt_q <= cnt_buf_i;
                        cmp_q <= cmp_buf_i;
                    end
                end else begin
                    cnt_q <= cnt_dec;
                    if (cnt_dec == cmp_q) level_q <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        pwm_o     = level_q ^ ctrl_i.invert;
        wrap_o    = wrap_q;
        running_o = (state_q == CH_RUN);
        cnt_o     = cnt_q;
    end

endmodule

// File: rtl/pwmt_bank.sv
module pwmt_bank
    import pwmt_pkg::*;
#(
    parameter  int unsigned NUM_CH = 4,
    parameter  int unsigned CNT_W  = 16,
    localparam int unsigned ADDR_W = $clog2(4 + 2 * NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_wrap
);

    ch_ctrl_t [NUM_CH-1:0]          ch_ctrl;
    logic [NUM_CH-1:0][1:0]         ch_div;
    logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt_buf, ch_cmp_buf, ch_cnt;
    logic [NUM_CH-1:0]              ch_run, ch_manual, ch_inv;

    pwmt_regs #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .rdata_o   (bus_rdata),
        .ctrl_o    (ch_ctrl),
        .div_o     (ch_div),
        .cnt_buf_o (ch_cnt_buf),
        .cmp_buf_o (ch_cmp_buf)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctrl_i    (ch_ctrl[g]),
            .div_i     (ch_div[g]),
            .cnt_buf_i (ch_cnt_buf[g]),
            .cmp_buf_i (ch_cmp_buf[g]),
            .pwm_o     (pwm_out[g]),
            .wrap_o    (pwm_wrap[g]),
            .running_o (ch_run[g]),
            .cnt_o     (ch_cnt[g])
        );
        assign ch_manual[g] = ch_ctrl[g].manual;
        assign ch_inv[g]    = ch_ctrl[g].invert;
    end

endmodule

// File: rtl/pwmt_bank_chk.sv
module pwmt_bank_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_i,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_buf_i,
    input logic [NUM_CH-1:0]            run_i,
    input logic [NUM_CH-1:0]            manual_i,
    input logic [NUM_CH-1:0]            inv_i,
    input logic [NUM_CH-1:0]            wrap_i,
    input logic [NUM_CH-1:0]            pwm_i
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run_i[g]) && !$past(manual_i[g]) && !wrap_i[g] && (cnt_i[g] != $past(cnt_i[g])))
            |-> (cnt_i[g] == $past(cnt_i[g]) - CNT_W'(1)))
            else $error("count step violated on channel %0d", g);

        p_manual_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $past(manual_i[g]) |-> (cnt_i[g] == $past(cnt_buf_i[g])))
            else $error("manual load violated on channel %0d", g);

        p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(run_i[g]) && !$past(manual_i[g])) |-> $stable(cnt_i[g]))
            else $error("halted counter moved on channel %0d", g);

        p_wrap_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_i[g] |=> !wrap_i[g])
            else $error("wrap longer than one cycle on channel %0d", g);

        p_low_at_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            wrap_i[g] |-> (pwm_i[g] == inv_i[g]))
            else $error("level not low at wrap on channel %0d", g);
    end

endmodule

bind pwmt_bank pwmt_bank_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (ch_cnt),
    .cnt_buf_i (ch_cnt_buf),
    .run_i     (ch_run),
    .manual_i  (ch_manual),
    .inv_i     (ch_inv),
    .wrap_i    (pwm_wrap),
    .pwm_i     (pwm_out)
);

// File: tb/pwmt_bank_tb.sv
module pwmt_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out, pwm_wrap;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    pwmt_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .pwm_wrap(pwm_wrap)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 150000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int unsigned d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int unsigned d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    function automatic int fbase(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    task automatic ctrl_set(input int ch, input int unsigned bits4);
        int unsigned w;
        bus_read(0, w);
        w = (w & ~(32'hF << fbase(ch))) | ((bits4 & 32'hF) << fbase(ch));
        bus_write(0, w);
    endtask

    // bits4 encoding: bit0 run, bit1 manual, bit2 invert, bit3 repeat
    task automatic setup_ch(input int ch, input int div, input int n, input int c,
                            input bit inv, input bit rpt);
        int unsigned w;
        bus_read(1, w);
        w = (w & ~(32'h3 << (2*ch))) | (32'(div) << (2*ch));
        bus_write(1, w);
        bus_write(4 + 2*ch, n);
        bus_write(5 + 2*ch, c);
        ctrl_set(ch, {rpt, inv, 1'b1, 1'b0});
        ctrl_set(ch, {rpt, inv, 1'b0, 1'b1});
    endtask

    task automatic measure(input int ch, output int hi, output int lo);
        hi = 0; lo = 0;
        do @(negedge clk); while (pwm_out[ch] !== 1'b0);
        do @(negedge clk); while (pwm_out[ch] !== 1'b1);
        while (pwm_out[ch] === 1'b1) begin hi++; @(negedge clk); end
        while (pwm_out[ch] === 1'b0) begin lo++; @(negedge clk); end
    endtask

    task automatic wait_wrap(input int ch, output int at);
        do @(negedge clk); while (pwm_wrap[ch] !== 1'b1);
        at = cyc;
    endtask

    task automatic window(input int ch, input int len, output int hi, output int wraps);
        hi = 0; wraps = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
            if (pwm_wrap[ch]) wraps++;
        end
    endtask

    task automatic t_reset;
        int unsigned d;
        for (int a = 0; a < 12; a++) begin
            bus_read(a, d);
            check(d == 0, "R1", $sformatf("reg %0d after reset", a), int'(d), 0);
        end
        check(pwm_out == 0, "R1", "pwm_out after reset", pwm_out, 0);
        check(pwm_wrap == 0, "R1", "pwm_wrap after reset", pwm_wrap, 0);
    endtask

    task automatic t_regmap;
        int unsigned d;
        bus_write(0, 32'hFFFF_FFFF);
        bus_read(0, d);
        check(d == 32'h000F_FF0F, "R2", "control field layout", int'(d), 32'h000F_FF0F);
        bus_write(0, 0);
        bus_write(1, 32'hE4);
        bus_read(1, d);
        check(d == 32'hE4, "R2", "prescale readback", int'(d), 32'hE4);
        bus_write(8, 32'h1234);
        bus_read(8, d);
        check(d == 32'h1234, "R2", "ch2 count buffer", int'(d), 32'h1234);
        bus_write(11, 32'hBEEF);
        bus_read(11, d);
        check(d == 32'hBEEF, "R2", "ch3 compare buffer", int'(d), 32'hBEEF);
        bus_write(1, 0);
    endtask

    task automatic t_basic;
        int hi, lo, t0, t1;
        setup_ch(0, 0, 9, 3, 1'b0, 1'b1);
        measure(0, hi, lo);
        check(hi == 8, "R6", "ch0 high cycles", hi, 8);
        check(lo == 12, "R6", "ch0 low cycles", lo, 12);
        wait_wrap(0, t0);
        wait_wrap(0, t1);
        check(t1 - t0 == 20, "R4", "ch0 wrap interval", t1 - t0, 20);
    endtask

    task automatic t_invert;
        int hi, lo;
        setup_ch(1, 1, 4, 1, 1'b1, 1'b1);
        measure(1, hi, lo);
        check(hi == 12, "R10", "ch1 inverted high cycles", hi, 12);
        check(lo == 8, "R10", "ch1 inverted low cycles", lo, 8);
    endtask

    task automatic t_prescale;
        int hi, lo;
        setup_ch(2, 3, 3, 1, 1'b0, 1'b1);
        setup_ch(3, 2, 2, 0, 1'b0, 1'b1);
        measure(2, hi, lo);
        check(hi == 32 && lo == 32, "R5", "div16 high cycles (low 32)", hi, 32);
        measure(3, hi, lo);
        check(hi == 8, "R5", "div8 high cycles", hi, 8);
        check(lo == 16, "R5", "div8 low cycles", lo, 16);
    endtask

    task automatic t_equal;
        int hi, wraps;
        setup_ch(3, 0, 5, 5, 1'b0, 1'b1);
        window(3, 100, hi, wraps);
        check(hi == 0, "R7", "high cycles with compare==count", hi, 0);
        check(wraps >= 5, "R7", "wraps while silent", wraps, 5);
    endtask

    task automatic t_buffered;
        int t0, t1, hi, lo;
        wait_wrap(0, t0);
        bus_write(4, 5);
        bus_write(5, 1);
        wait_wrap(0, t1);
        check(t1 - t0 == 20, "R8", "period after mid-period buffer write", t1 - t0, 20);
        measure(0, hi, lo);
        check(hi == 4, "R8", "ch0 new high cycles", hi, 4);
        check(lo == 8, "R8", "ch0 new low cycles", lo, 8);
    endtask

    task automatic t_oneshot;
        int hi, wraps;
        ctrl_set(1, 0);
        setup_ch(1, 0, 4, 1, 1'b0, 1'b0);
        window(1, 100, hi, wraps);
        check(wraps == 1, "R9", "single-period wrap count", wraps, 1);
        check(hi == 4, "R3 R9", "single-period high cycles", hi, 4);
        check(pwm_out[1] == 1'b0, "R9", "pin after single period", pwm_out[1], 0);
    endtask

    task automatic t_stop;
        int hi, wraps, wraps2, chg;
        logic held;
        ctrl_set(0, 4'b1000);
        repeat (2) @(negedge clk);
        held = pwm_out[0];
        chg = 0; wraps = 0; wraps2 = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (pwm_out[0] !== held) chg++;
            if (pwm_wrap[0]) wraps++;
            if (pwm_wrap[2]) wraps2++;
        end
        check(chg == 0, "R11", "halted pin changes", chg, 0);
        check(wraps == 0, "R11", "halted wraps", wraps, 0);
        check(wraps2 >= 1, "R11", "other channel wraps", wraps2, 1);
        hi = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_basic;
        t_invert;
        t_prescale;
        t_equal;
        t_buffered;
        t_oneshot;
        t_stop;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule